// File: doc/BRIEF.md
# Two-Sided Process Queue Scheduler

This block holds the pending program counters of two programs that compete inside a circular core of `CORE_SIZE` locations. Each side owns a first-in first-out queue of process addresses. The scheduler serves the sides in strict turn: side 0 first, then side 1. On each turn it takes the oldest address of the active side and offers it to the execute unit on a dispatch stream. It then waits for the execute unit to return the outcome of that instruction.

The outcome decides what goes back onto the same side's queue. A halt returns nothing. A plain step returns the next address. A taken branch returns its target. A spawn returns the next address and then the spawned target, and the target is dropped when the queue has no room for it. The scheduler declares a winner when a side runs out of processes. It declares a draw after a fixed number of complete rounds. A `start` pulse loads one entry address per side and restarts the game at any time.

Both streams use valid/ready. A dispatch offer holds its address and side steady until `disp_ready` is seen high at a clock edge. Only one instruction is outstanding at a time. `res_ready` is high only while an outcome is awaited, and while it is low any outcome on the result stream is ignored.

Top module: `proc_sched`

## Requirements
- R1: After reset, `running` is 0, `verdict` is 0 (none), and both `disp_valid` and `res_ready` are 0.
- R2: A `start` pulse clears both queues and loads `entry0` and `entry1`, each reduced modulo `CORE_SIZE`, one per side. It clears the verdict and the round count. The first dispatch is then side 0 with its entry address, and the next one is side 1 with its entry address.
- R3: Dispatches alternate strictly, side 0, side 1, side 0, and so on. Only one instruction is outstanding at a time. `disp_valid` and `res_ready` are never high together. Outcomes offered while `res_ready` is 0 leave the queues unchanged.
- R4: While `disp_valid` is 1 and `disp_ready` is 0, the next cycle still offers the same `disp_pc` and `disp_side`.
- R5: Outcome kind 1 (step) pushes the dispatched address plus one, modulo `CORE_SIZE`, so `CORE_SIZE-1` is followed by 0.
- R6: Outcome kind 2 (branch) pushes `res_target` reduced modulo `CORE_SIZE`.
- R7: Outcome kind 0 (halt) pushes nothing, so that process is removed from its side.
- R8: Outcome kind 3 (spawn) first pushes the dispatched address plus one, then pushes the reduced `res_target`. The target is pushed only if the queue still has a free slot after the first push.
- R9: Each side serves its processes in the order in which they were pushed.
- R10: When a halt leaves the active side's queue empty, the other side wins. `verdict` becomes 1 if side 0 wins and 2 if side 1 wins. `running` drops, and nothing more is dispatched until the next `start`.
- R11: When side 1's outcome completes round number `MAX_ROUNDS` and neither queue is empty, `verdict` becomes 3 (draw) and `running` drops.
- R12: A `start` pulse while a game is running abandons that game. The new game begins from the new entry addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load entry addresses and begin a game |
| entry0 | input | ADDR_W | Entry address of side 0 |
| entry1 | input | ADDR_W | Entry address of side 1 |
| disp_valid | output | 1 | Dispatch offer present |
| disp_ready | input | 1 | Execute unit takes the dispatch |
| disp_side | output | 1 | Side of the dispatched process |
| disp_pc | output | ADDR_W | Address of the dispatched process |
| res_valid | input | 1 | Outcome present |
| res_ready | output | 1 | Scheduler awaits an outcome |
| res_kind | input | 2 | 0 halt, 1 step, 2 branch, 3 spawn |
| res_target | input | ADDR_W | Branch or spawn address |
| running | output | 1 | A game is in progress |
| verdict | output | 2 | 0 none, 1 side 0 wins, 2 side 1 wins, 3 draw |

## Verification
A dispatch is due in the cycle after `start`, or in the cycle after an outcome is accepted. The bench waits for `disp_valid` at the falling edge, checks the offered side and address there, and then drives `disp_ready` for one edge. `res_ready` rises in the cycle after the dispatch handshake. The verdict and `running` change at the same edge that accepts the outcome, so the bench checks them at the next falling edge. That edge comes before any further handshake, so each check sees exactly one outcome's effect.

// File: rtl/proc_sched_pkg.sv
package proc_sched_pkg;
  typedef enum logic [1:0] {
    K_HALT  = 2'd0,
    K_STEP  = 2'd1,
    K_JUMP  = 2'd2,
    K_SPAWN = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_SIDE0 = 2'd1,
    V_SIDE1 = 2'd2,
    V_DRAW  = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DISP = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/proc_fifo2.sv
module proc_fifo2 #(
  parameter int DEPTH = 64,
  parameter int W     = 13,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic          pa_en,
  input  logic [W-1:0]  pa_data,
  input  logic          pb_en,
  input  logic [W-1:0]  pb_data,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, wr_ptr1;
  logic [1:0]    npush;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head    = mem[rd_ptr];
  assign wr_ptr1 = nxt(wr_ptr);
  assign npush   = {1'b0, pa_en} + {1'b0, pb_en};

  always_ff @(posedge clk) begin
    if (clr) begin
      if (pa_en) mem[0] <= pa_data;
    end else begin
      if (pa_en) mem[wr_ptr] <= pa_data;
      if (pb_en) mem[pa_en ? wr_ptr1 : wr_ptr] <= pb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= pa_en ? PW'(1 % DEPTH) : '0;
      count  <= CW'(pa_en);
    end else begin
      if (pop) rd_ptr <= nxt(rd_ptr);
      case (npush)
        2'd1:    wr_ptr <= wr_ptr1;
        2'd2:    wr_ptr <= nxt(wr_ptr1);
        default: wr_ptr <= wr_ptr;
      endcase
      count <= count + CW'(npush) - CW'(pop);
    end
  end

  // R8: the controller never pushes more than the free space
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (int'(count) + int'(npush) - int'(pop)) <= DEPTH);
  // R7: a pop never hits an empty queue
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    pop |-> (count != '0));
  // R8: the second push only follows a first push
  p_pb_needs_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pb_en |-> pa_en);
endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
  import proc_sched_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int CORE_SIZE  = 8000,
  parameter int DEPTH      = 64,
  parameter int MAX_ROUNDS = 1000,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int RW        = $clog2(MAX_ROUNDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          entry0,
  input  logic [ADDR_W-1:0]          entry1,
  output logic                       disp_valid,
  input  logic                       disp_ready,
  output logic                       disp_side,
  output logic [ADDR_W-1:0]          disp_pc,
  input  logic                       res_valid,
  output logic                       res_ready,
  input  logic [1:0]                 res_kind,
  input  logic [ADDR_W-1:0]          res_target,
  output logic                       running,
  output logic [1:0]                 verdict,
  input  logic [1:0][ADDR_W-1:0]     q_head,
  input  logic [1:0][CW-1:0]         q_count,
  output logic                       q_clr,
  output logic [1:0]                 q_pop,
  output logic [1:0]                 q_pa_en,
  output logic [1:0][ADDR_W-1:0]     q_pa_data,
  output logic [1:0]                 q_pb_en,
  output logic [ADDR_W-1:0]          q_pb_data
);
  phase_e              phase;
  verdict_e            verdict_q;
  logic                side_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [RW-1:0]       rounds_q;
  logic                disp_fire, res_fire, lost, room2;
  logic [ADDR_W-1:0]   pc_inc, tgt_mod;
  outcome_e            kind;

  function automatic logic [ADDR_W-1:0] reduce(input logic [ADDR_W-1:0] a);
    return (int'(a) >= CORE_SIZE) ? ADDR_W'(int'(a) - CORE_SIZE) : a;
  endfunction

  assign kind       = outcome_e'(res_kind);
  assign disp_valid = (phase == PH_DISP);
  assign disp_side  = side_q;
  assign disp_pc    = q_head[side_q];
  assign res_ready  = (phase == PH_WAIT);
  assign disp_fire  = disp_valid && disp_ready && !start;
  assign res_fire   = res_valid && res_ready && !start;
  assign running    = (phase == PH_DISP) || (phase == PH_WAIT);
  assign verdict    = verdict_q;
  assign pc_inc     = (int'(pc_q) == CORE_SIZE - 1) ? '0 : pc_q + 1'b1;
  assign tgt_mod    = reduce(res_target);
  assign room2      = int'(q_count[side_q]) <= DEPTH - 2;
  assign lost       = res_fire && (kind == K_HALT) && (q_count[side_q] == '0);

  always_comb begin
    q_clr     = start;
    q_pop     = '0;
    q_pa_en   = '0;
    q_pb_en   = '0;
    q_pa_data = '0;
    q_pb_data = tgt_mod;
    if (start) begin
      q_pa_en      = 2'b11;
      q_pa_data[0] = reduce(entry0);
      q_pa_data[1] = reduce(entry1);
    end else begin
      q_pop[side_q] = disp_fire;
      if (res_fire) begin
        case (kind)
          K_STEP: begin
            q_pa_en[side_q]   = 1'b1;
            q_pa_data[side_q] = pc_inc;
          end
          K_JUMP: begin
            q_pa_en[side_q]   = 1'b1;
            q_pa_data[side_q] = tgt_mod;
          end
          K_SPAWN: begin
            q_pa_en[side_q]   = 1'b1;
            q_pa_data[side_q] = pc_inc;
            q_pb_en[side_q]   = room2;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      verdict_q <= V_NONE;
      side_q    <= 1'b0;
      pc_q      <= '0;
      rounds_q  <= '0;
    end else if (start) begin
      phase     <= PH_DISP;
      verdict_q <= V_NONE;
      side_q    <= 1'b0;
      rounds_q  <= '0;
    end else begin
      case (phase)
        PH_DISP: if (disp_fire) begin
          pc_q  <= disp_pc;
          phase <= PH_WAIT;
        end
        PH_WAIT: if (res_fire) begin
          if (lost) begin
            verdict_q <= side_q ? V_SIDE0 : V_SIDE1;
            phase     <= PH_DONE;
          end else if (side_q && (int'(rounds_q) == MAX_ROUNDS - 1)) begin
            verdict_q <= V_DRAW;
            phase     <= PH_DONE;
          end else begin
            if (side_q) rounds_q <= rounds_q + 1'b1;
            side_q <= ~side_q;
            phase  <= PH_DISP;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: offer and outcome windows never overlap
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && res_ready));
  // R3: after a non-final outcome the other side is offered next
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n || start)
    (res_fire && !lost && !(side_q && int'(rounds_q) == MAX_ROUNDS - 1))
    |=> (disp_valid && (disp_side != $past(side_q))));
  // R4: a stalled offer stays put
  p_disp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || start)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_pc) && $stable(disp_side)));
  // R10: no offers once a verdict is out
  p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != 2'd0) |-> !disp_valid);
  // R10: an emptied side ends the game at once
  p_defeat_r10: assert property (@(posedge clk) disable iff (!rst_n || start)
    lost |=> (!running && verdict != 2'd0 && verdict != 2'd3));
endmodule

// File: rtl/proc_sched.sv
module proc_sched #(
  parameter int ADDR_W     = 13,
  parameter int CORE_SIZE  = 8000,
  parameter int DEPTH      = 64,
  parameter int MAX_ROUNDS = 1000,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] entry0,
  input  logic [ADDR_W-1:0] entry1,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic              disp_side,
  output logic [ADDR_W-1:0] disp_pc,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [1:0]        res_kind,
  input  logic [ADDR_W-1:0] res_target,
  output logic              running,
  output logic [1:0]        verdict
);
  logic [1:0][ADDR_W-1:0] q_head;
  logic [1:0][CW-1:0]     q_count;
  logic                   q_clr;
  logic [1:0]             q_pop, q_pa_en, q_pb_en;
  logic [1:0][ADDR_W-1:0] q_pa_data;
  logic [ADDR_W-1:0]      q_pb_data;

  proc_ctrl #(
    .ADDR_W(ADDR_W), .CORE_SIZE(CORE_SIZE), .DEPTH(DEPTH), .MAX_ROUNDS(MAX_ROUNDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .entry0(entry0), .entry1(entry1),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_side(disp_side),
    .disp_pc(disp_pc), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_target(res_target), .running(running),
    .verdict(verdict), .q_head(q_head), .q_count(q_count), .q_clr(q_clr),
    .q_pop(q_pop), .q_pa_en(q_pa_en), .q_pa_data(q_pa_data),
    .q_pb_en(q_pb_en), .q_pb_data(q_pb_data)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    proc_fifo2 #(.DEPTH(DEPTH), .W(ADDR_W)) u_q (
      .clk(clk), .rst_n(rst_n), .clr(q_clr), .pop(q_pop[s]),
      .pa_en(q_pa_en[s]), .pa_data(q_pa_data[s]),
      .pb_en(q_pb_en[s]), .pb_data(q_pb_data),
      .head(q_head[s]), .count(q_count[s])
    );
  end

  // R1: quiet after reset until a start arrives
  p_reset_quiet_r1: assert property (@(posedge clk)
    (!rst_n) |=> (!running && verdict == 2'd0 && !disp_valid && !res_ready));
  // R12: a start always yields a fresh side-0 offer
  p_start_fresh_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (disp_valid && !disp_side && verdict == 2'd0));
endmodule

// File: tb/proc_sched_tb.sv
module proc_sched_tb;
  localparam int AW = 13, CS = 8000, D = 4, MR = 40;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] entry0 = '0, entry1 = '0, res_target = '0;
  logic disp_ready = 0, res_valid = 0;
  logic [1:0] res_kind = '0;
  logic disp_valid, disp_side, res_ready, running;
  logic [AW-1:0] disp_pc;
  logic [1:0] verdict;

  int tests = 0, fails = 0;
  int mq[2][D];
  int mh[2], mc[2];
  int ms, mrounds, mverdict, mrun;

  always #2 clk = ~clk;

  proc_sched #(.ADDR_W(AW), .CORE_SIZE(CS), .DEPTH(D), .MAX_ROUNDS(MR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .entry0(entry0), .entry1(entry1),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_side(disp_side),
    .disp_pc(disp_pc), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_target(res_target), .running(running), .verdict(verdict));

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void mpush(int s, int v);
    mq[s][(mh[s] + mc[s]) % D] = v % CS;
    mc[s]++;
  endfunction

  task automatic do_start(int e0, int e1);
    @(negedge clk);
    entry0 = AW'(e0); entry1 = AW'(e1); start = 1;
    @(negedge clk);
    start = 0;
    mh = '{0, 0}; mc = '{0, 0};
    mpush(0, e0); mpush(1, e1);
    ms = 0; mrounds = 0; mverdict = 0; mrun = 1;
  endtask

  // one turn: check the offer, take it, return an outcome, check the status
  task automatic serve(int kind, int tgt, int hold, string tag);
    int p;
    while (!disp_valid) @(negedge clk);
    p = mq[ms][mh[ms]];
    check(tag, "disp_side", int'(disp_side), ms);
    check(tag, "disp_pc", int'(disp_pc), p);
    if (hold > 0) begin
      res_valid = 1; res_kind = 2'd0; res_target = '0;
      repeat (hold) @(negedge clk);
      res_valid = 0;
      check("R4", "held disp_pc", int'(disp_pc), p);
      check("R4", "held disp_valid", int'(disp_valid), 1);
      check("R3", "res_ready while offering", int'(res_ready), 0);
    end
    disp_ready = 1;
    @(negedge clk);
    disp_ready = 0;
    mh[ms] = (mh[ms] + 1) % D; mc[ms]--;
    check("R3", "res_ready after take", int'(res_ready), 1);
    res_valid = 1; res_kind = 2'(kind); res_target = AW'(tgt);
    @(negedge clk);
    res_valid = 0;
    case (kind)
      1: mpush(ms, p + 1);
      2: mpush(ms, tgt);
      3: begin mpush(ms, p + 1); if (mc[ms] < D) mpush(ms, tgt); end
      default: ;
    endcase
    if (mc[ms] == 0) begin
      mverdict = (ms == 0) ? 2 : 1; mrun = 0;
    end else begin
      if (ms == 1) begin
        mrounds++;
        if (mrounds == MR) begin mverdict = 3; mrun = 0; end
      end
      ms = 1 - ms;
    end
    check(mverdict == 3 ? "R11" : "R10", "verdict", int'(verdict), mverdict);
    check(mverdict == 3 ? "R11" : "R10", "running", int'(running), mrun);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed, k, r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "running", int'(running), 0);
    check("R1", "verdict", int'(verdict), 0);
    check("R1", "disp_valid", int'(disp_valid), 0);
    check("R1", "res_ready", int'(res_ready), 0);

    // R2: entries reduced, side 0 offered first; R5 wrap at the core end
    do_start(8005, 7999);
    serve(1, 0, 0, "R2");
    serve(1, 0, 2, "R2");          // side 1 entry 7999 -> pushes 0 (R5); stalled offer R4/R3
    serve(3, 100, 0, "R5");        // side 0 pc 6 spawn 100 -> 7,100
    serve(2, 8100, 0, "R5");       // side 1 pc 0 branch 8100 -> 100 (R6)
    serve(3, 200, 0, "R9");        // side 0 pc 7 -> 100,8,200
    serve(1, 0, 0, "R6");          // side 1 pc 100
    serve(3, 300, 0, "R9");        // side 0 pc 100 -> 8,200,101,300 (full)
    serve(1, 0, 0, "R6");
    serve(3, 400, 0, "R8");        // side 0 pc 8 -> 400 dropped
    serve(0, 0, 0, "R8");          // side 1 halts its only process
    check("R10", "side0 wins", int'(verdict), 1);
    repeat (3) @(negedge clk);
    check("R10", "no offer after verdict", int'(disp_valid), 0);

    // R12: restart mid-game, then side 0 loses
    do_start(10, 20);
    serve(1, 0, 0, "R12");
    do_start(30, 40);
    serve(0, 0, 0, "R12");
    check("R7", "side1 wins", int'(verdict), 2);

    // R11: draw after MR rounds
    do_start(1, 2);
    for (int i = 0; i < 2 * MR; i++) serve(1, 0, 0, "R11");
    check("R11", "draw", int'(verdict), 3);

    // random games
    for (int g = 0; g < 40; g++) begin
      do_start($urandom_range(0, 8191), $urandom_range(0, 8191));
      while (mrun == 1) begin
        r = $urandom_range(0, 99);
        k = (r < 8) ? 0 : (r < 45) ? 1 : (r < 70) ? 2 : 3;
        serve(k, $urandom_range(0, 8191), (r % 7 == 0) ? 1 : 0, "R9");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule